// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces horizontal sync, vertical sync and data-enable for a parallel RGB display, together with the pixel column and row inside the visible area and a one-clock wake pulse on a chosen line. One pixel is produced per clock. The timing comes from configuration inputs. Horizontal values count pairs of pixel clocks, stored as (pairs - 1). Vertical values count lines, stored as (lines - 1). The wake line is a plain line index.

The configuration inputs are copied into a shadow bank. The counters and compare logic read only that bank. The bank reloads on reset, and at the last pixel of a frame while the update-enable input is high. Software can therefore rewrite the timing at any moment without tearing a frame. Each output can be made active-low through a polarity field.

Top module: `lcd_sync_gen`

## Requirements
- R1: While `rst` is high, the next clock edge drives every sync and enable output to its inactive level. The inactive level is 0, or 1 when the matching `cfg_pol` bit is set. The same edge clears `px_x`, `px_y` and `wake_o`, restarts the frame at column 0 of line 0, and loads the shadow bank from the configuration inputs.
- R2: A line lasts (`htotal`+1)*2 clocks. Horizontal sync is active during the first (`hsync`+1)*2 clocks of each line.
- R3: A frame lasts `vtotal`+1 lines. Vertical sync is active during the first `vsync`+1 lines of the frame.
- R4: Data-enable is active when the column lies in [(`hstart`+1)*2, (`hstart`+1)*2 + (`hsize`+1)*2) and the line lies in [`vstart`+1, `vstart`+1 + `vsize`+1).
- R5: While data-enable is active, `px_x` and `px_y` give the column and line offsets from the start of the active window. Both are 0 whenever data-enable is inactive.
- R6: `wake_o` pulses high for exactly one clock, at column 0 of the line whose index equals `wake_line`. Line 0 is the first line of the frame.
- R7: `cfg_pol` bit 0 inverts horizontal sync, bit 1 inverts vertical sync and bit 2 inverts data-enable. A bit value of 1 makes that output active-low.
- R8: Changes to the configuration inputs, including polarity, have no effect while `cfg_update` is low. While `cfg_update` is high, the shadow bank reloads at the last clock of a frame, so the next frame starts entirely with the new timing.
- R9: Every output is registered. The values seen after a clock edge belong to the counter position held before that edge, so the first edge after reset shows column 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_htotal | input | H_REG_W | Line length, pairs of clocks minus one |
| cfg_hsync | input | H_REG_W | Horizontal sync width, pairs minus one |
| cfg_hstart | input | H_REG_W | First active column, pairs minus one |
| cfg_hsize | input | H_REG_W | Active width, pairs minus one |
| cfg_vtotal | input | V_REG_W | Frame length, lines minus one |
| cfg_vsync | input | V_REG_W | Vertical sync width, lines minus one |
| cfg_vstart | input | V_REG_W | First active line minus one |
| cfg_vsize | input | V_REG_W | Active height, lines minus one |
| cfg_wake_line | input | V_REG_W | Line index of the wake pulse |
| cfg_pol | input | 3 | Active-low select: bit0 hsync, bit1 vsync, bit2 data-enable |
| cfg_update | input | 1 | Allows the shadow bank to reload at frame end |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| px_x | output | H_REG_W+2 | Column inside the active window |
| px_y | output | V_REG_W+2 | Line inside the active window |
| wake_o | output | 1 | One-clock wake pulse |

## Verification
The shadow reload and the output of a frame's final pixel happen on the same clock edge. That edge must emit the last position using the old timing and old polarity, while the following edge already runs on the new bank. The bench provokes this case by raising `cfg_update` in the middle of a frame in which the configuration has already changed, including an inverted polarity. A reference model that reloads its own copy at the frame wrap then predicts every clock across the boundary. A second coincidence, a wake pulse on line 0 together with the start of vertical sync, is covered by a configuration whose wake line is 0.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  // positions inside the polarity field
  localparam int POL_HS = 0;
  localparam int POL_VS = 1;
  localparam int POL_DE = 2;
  localparam int POL_W  = 3;

  // axis scaling variants
  localparam int UNIT_LINE = 0;  // value+1 counts
  localparam int UNIT_PAIR = 1;  // (value+1)*2 counts
endpackage

// File: rtl/lcd_axis_timer.sv
module lcd_axis_timer #(
  parameter int REG_W      = 10,
  parameter int UNIT_SHIFT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [REG_W-1:0] r_total,
  input  logic [REG_W-1:0] r_sync,
  input  logic [REG_W-1:0] r_start,
  input  logic [REG_W-1:0] r_size,
  output logic [REG_W+1:0] cnt,
  output logic             at_end,
  output logic             sync_on,
  output logic             in_active,
  output logic [REG_W+1:0] offset
);
  localparam int CNT_W = REG_W + 2;
  localparam int EXT_W = REG_W + 3;

  logic [EXT_W-1:0] len_total, len_sync, pos_start, len_size;
  logic [EXT_W-1:0] pos_stop, cnt_ext;

  generate
    if (UNIT_SHIFT == 0) begin : g_unit_line
      assign len_total = EXT_W'(r_total) + EXT_W'(1);
      assign len_sync  = EXT_W'(r_sync)  + EXT_W'(1);
      assign pos_start = EXT_W'(r_start) + EXT_W'(1);
      assign len_size  = EXT_W'(r_size)  + EXT_W'(1);
    end else begin : g_unit_pair
      assign len_total = (EXT_W'(r_total) + EXT_W'(1)) << 1;
      assign len_sync  = (EXT_W'(r_sync)  + EXT_W'(1)) << 1;
      assign pos_start = (EXT_W'(r_start) + EXT_W'(1)) << 1;
      assign len_size  = (EXT_W'(r_size)  + EXT_W'(1)) << 1;
    end
  endgenerate

  assign cnt_ext   = EXT_W'(cnt);
  assign pos_stop  = pos_start + len_size;
  assign at_end    = (cnt_ext == len_total - EXT_W'(1));
  assign sync_on   = (cnt_ext < len_sync);
  assign in_active = (cnt_ext >= pos_start) && (cnt_ext < pos_stop);
  assign offset    = in_active ? CNT_W'(cnt_ext - pos_start) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (advance) begin
      cnt <= at_end ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lcd_shadow_bank.sv
module lcd_shadow_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int H_REG_W = 10,
  parameter int V_REG_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [H_REG_W-1:0] cfg_htotal,
  input  logic [H_REG_W-1:0] cfg_hsync,
  input  logic [H_REG_W-1:0] cfg_hstart,
  input  logic [H_REG_W-1:0] cfg_hsize,
  input  logic [V_REG_W-1:0] cfg_vtotal,
  input  logic [V_REG_W-1:0] cfg_vsync,
  input  logic [V_REG_W-1:0] cfg_vstart,
  input  logic [V_REG_W-1:0] cfg_vsize,
  input  logic [V_REG_W-1:0] cfg_wake_line,
  input  logic [2:0]         cfg_pol,
  input  logic               cfg_update,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [H_REG_W+1:0] px_x,
  output logic [V_REG_W+1:0] px_y,
  output logic               wake_o
);
  localparam int HC_W = H_REG_W + 2;
  localparam int VC_W = V_REG_W + 2;
  localparam int SH_W = 4 * H_REG_W + 5 * V_REG_W + POL_W;

  // shadowed configuration
  logic [SH_W-1:0]    shadow_d, shadow_q;
  logic               shadow_load;
  logic [H_REG_W-1:0] sh_htotal, sh_hsync, sh_hstart, sh_hsize;
  logic [V_REG_W-1:0] sh_vtotal, sh_vsync, sh_vstart, sh_vsize, sh_wake;
  logic [POL_W-1:0]   sh_pol;

  assign shadow_d = {cfg_pol, cfg_wake_line, cfg_vsize, cfg_vstart, cfg_vsync,
                     cfg_vtotal, cfg_hsize, cfg_hstart, cfg_hsync, cfg_htotal};
  assign {sh_pol, sh_wake, sh_vsize, sh_vstart, sh_vsync,
          sh_vtotal, sh_hsize, sh_hstart, sh_hsync, sh_htotal} = shadow_q;

  // axis state
  logic [HC_W-1:0] h_cnt, h_off;
  logic [VC_W-1:0] v_cnt, v_off;
  logic            h_end, h_sync, h_act;
  logic            v_end, v_sync, v_act;
  logic            frame_end, de_raw, wake_hit;

  assign frame_end   = h_end && v_end;
  assign shadow_load = frame_end && cfg_update;

  lcd_shadow_bank #(.WIDTH(SH_W)) u_shadow (
    .clk  (clk),
    .rst  (rst),
    .load (shadow_load),
    .d    (shadow_d),
    .q    (shadow_q)
  );

  lcd_axis_timer #(.REG_W(H_REG_W), .UNIT_SHIFT(UNIT_PAIR)) u_haxis (
    .clk       (clk),
    .rst       (rst),
    .advance   (1'b1),
    .r_total   (sh_htotal),
    .r_sync    (sh_hsync),
    .r_start   (sh_hstart),
    .r_size    (sh_hsize),
    .cnt       (h_cnt),
    .at_end    (h_end),
    .sync_on   (h_sync),
    .in_active (h_act),
    .offset    (h_off)
  );

  lcd_axis_timer #(.REG_W(V_REG_W), .UNIT_SHIFT(UNIT_LINE)) u_vaxis (
    .clk       (clk),
    .rst       (rst),
    .advance   (h_end),
    .r_total   (sh_vtotal),
    .r_sync    (sh_vsync),
    .r_start   (sh_vstart),
    .r_size    (sh_vsize),
    .cnt       (v_cnt),
    .at_end    (v_end),
    .sync_on   (v_sync),
    .in_active (v_act),
    .offset    (v_off)
  );

  assign de_raw   = h_act && v_act;
  assign wake_hit = (v_cnt == VC_W'(sh_wake)) && (h_cnt == '0);

  // registered outputs, polarity applied last
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= cfg_pol[POL_HS];
      vsync_o <= cfg_pol[POL_VS];
      de_o    <= cfg_pol[POL_DE];
      px_x    <= '0;
      px_y    <= '0;
      wake_o  <= 1'b0;
    end else begin
      hsync_o <= h_sync ^ sh_pol[POL_HS];
      vsync_o <= v_sync ^ sh_pol[POL_VS];
      de_o    <= de_raw ^ sh_pol[POL_DE];
      px_x    <= de_raw ? h_off : '0;
      px_y    <= de_raw ? v_off : '0;
      wake_o  <= wake_hit;
    end
  end
endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
  parameter int H_REG_W = 10,
  parameter int V_REG_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic [H_REG_W+1:0] h_cnt,
  input logic [V_REG_W+1:0] v_cnt,
  input logic [H_REG_W-1:0] sh_htotal,
  input logic [V_REG_W-1:0] sh_vtotal,
  input logic               shadow_load,
  input logic [4*H_REG_W+5*V_REG_W+2:0] shadow_q,
  input logic               wake_o
);
  localparam int HE_W = H_REG_W + 3;
  localparam int VE_W = V_REG_W + 3;

  logic [HE_W-1:0] h_len;
  assign h_len = (HE_W'(sh_htotal) + HE_W'(1)) << 1;

  // R2: column never reaches the programmed line length
  assert_hcnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    HE_W'(h_cnt) < h_len);

  // R2: column either restarts at 0 or advances by one
  assert_hcnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    (h_cnt != '0) |-> (h_cnt == $past(h_cnt) + 1'b1));

  // R3: line index stays inside the frame
  assert_vcnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    VE_W'(v_cnt) <= VE_W'(sh_vtotal));

  // R8: shadow bank holds outside a permitted frame-end reload
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !shadow_load |=> $stable(shadow_q));

  // R6: wake pulse lasts one clock
  assert_wake_single_R6: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);
endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.H_REG_W(H_REG_W), .V_REG_W(V_REG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .h_cnt       (h_cnt),
  .v_cnt       (v_cnt),
  .sh_htotal   (sh_htotal),
  .sh_vtotal   (sh_vtotal),
  .shadow_load (shadow_load),
  .shadow_q    (shadow_q),
  .wake_o      (wake_o)
);

// File: tb/lcd_sync_gen_test.sv
module lcd_sync_gen_test;
  localparam int HW = 10;
  localparam int VW = 10;

  typedef struct {
    int    hs, vs, de, x, y, wk;
    string ph;
    bit    in_rst;
  } exp_t;

  logic clk = 1'b0;
  logic rst;
  logic [HW-1:0] cfg_htotal, cfg_hsync, cfg_hstart, cfg_hsize;
  logic [VW-1:0] cfg_vtotal, cfg_vsync, cfg_vstart, cfg_vsize, cfg_wake_line;
  logic [2:0]    cfg_pol;
  logic          cfg_update;
  logic hsync_o, vsync_o, de_o, wake_o;
  logic [HW+1:0] px_x;
  logic [VW+1:0] px_y;

  always #10 clk = ~clk;  // 50 MHz

  lcd_sync_gen #(.H_REG_W(HW), .V_REG_W(VW)) uut (
    .clk(clk), .rst(rst),
    .cfg_htotal(cfg_htotal), .cfg_hsync(cfg_hsync), .cfg_hstart(cfg_hstart),
    .cfg_hsize(cfg_hsize), .cfg_vtotal(cfg_vtotal), .cfg_vsync(cfg_vsync),
    .cfg_vstart(cfg_vstart), .cfg_vsize(cfg_vsize), .cfg_wake_line(cfg_wake_line),
    .cfg_pol(cfg_pol), .cfg_update(cfg_update),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .px_x(px_x), .px_y(px_y), .wake_o(wake_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  exp_t sb[$];
  string phase = "";

  // reference model state
  int m_h = 0, m_v = 0;
  int s_ht, s_hw, s_hs, s_hz, s_vt, s_vw, s_vs, s_vz, s_wk, s_pol;

  task automatic chk(string tag, string what, int got, int expv);
    n_checks++;
    if (got != expv) begin
      n_fail++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, expv, $time);
    end
  endtask

  task automatic set_cfg(int ht, int hw, int hs, int hz, int vt, int vw,
                         int vs, int vz, int wk, int pol);
    cfg_htotal = HW'(ht); cfg_hsync = HW'(hw); cfg_hstart = HW'(hs); cfg_hsize = HW'(hz);
    cfg_vtotal = VW'(vt); cfg_vsync = VW'(vw); cfg_vstart = VW'(vs); cfg_vsize = VW'(vz);
    cfg_wake_line = VW'(wk); cfg_pol = 3'(pol);
  endtask

  task automatic load_model();
    s_ht = int'(cfg_htotal); s_hw = int'(cfg_hsync); s_hs = int'(cfg_hstart);
    s_hz = int'(cfg_hsize);  s_vt = int'(cfg_vtotal); s_vw = int'(cfg_vsync);
    s_vs = int'(cfg_vstart); s_vz = int'(cfg_vsize);  s_wk = int'(cfg_wake_line);
    s_pol = int'(cfg_pol);
  endtask

  // driver: predict the next edge, advance the model, wait a cycle
  task automatic tick();
    exp_t e;
    int hx0, hx1, vy0, vy1, hact, vact;
    e.ph = phase;
    e.in_rst = rst;
    if (rst) begin
      e.hs = cfg_pol[0]; e.vs = cfg_pol[1]; e.de = cfg_pol[2];
      e.x = 0; e.y = 0; e.wk = 0;
      m_h = 0; m_v = 0;
      load_model();
    end else begin
      hx0 = (s_hs + 1) * 2; hx1 = hx0 + (s_hz + 1) * 2;
      vy0 = s_vs + 1;       vy1 = vy0 + s_vz + 1;
      hact = (m_h >= hx0 && m_h < hx1) ? 1 : 0;
      vact = (m_v >= vy0 && m_v < vy1) ? 1 : 0;
      e.hs = ((m_h < (s_hw + 1) * 2) ? 1 : 0) ^ (s_pol & 1);
      e.vs = ((m_v < s_vw + 1) ? 1 : 0) ^ ((s_pol >> 1) & 1);
      e.de = (hact & vact) ^ ((s_pol >> 2) & 1);
      e.x  = (hact & vact) != 0 ? m_h - hx0 : 0;
      e.y  = (hact & vact) != 0 ? m_v - vy0 : 0;
      e.wk = (m_v == s_wk && m_h == 0) ? 1 : 0;
      if (m_h == (s_ht + 1) * 2 - 1) begin
        m_h = 0;
        if (m_v == s_vt) begin
          m_v = 0;
          if (cfg_update) load_model();
        end else m_v++;
      end else m_h++;
    end
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // monitor: compare away from the active edge
  always begin
    exp_t e;
    @(posedge clk);
    #5;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      if (e.in_rst) begin
        chk("R1", "hsync", int'(hsync_o), e.hs);
        chk("R1", "vsync", int'(vsync_o), e.vs);
        chk("R1", "de",    int'(de_o),    e.de);
        chk("R1", "px_x",  int'(px_x),    e.x);
        chk("R1", "px_y",  int'(px_y),    e.y);
        chk("R1", "wake",  int'(wake_o),  e.wk);
      end else begin
        chk({"R2 R9 ", e.ph}, "hsync", int'(hsync_o), e.hs);
        chk({"R3 ", e.ph},    "vsync", int'(vsync_o), e.vs);
        chk({"R4 ", e.ph},    "de",    int'(de_o),    e.de);
        chk({"R5 ", e.ph},    "px_x",  int'(px_x),    e.x);
        chk({"R5 ", e.ph},    "px_y",  int'(px_y),    e.y);
        chk({"R6 ", e.ph},    "wake",  int'(wake_o),  e.wk);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // config A: line 20 clocks, frame 8 lines, active 6..13 x 2..4
    rst = 1'b1; cfg_update = 1'b0;
    set_cfg(9, 1, 2, 3, 7, 0, 1, 2, 6, 0);
    run(3);                          // R1 reset state
    rst = 1'b0;
    run(320);                        // two frames of A
    // R8: new timing without update enable is ignored
    phase = "R8";
    run(37);
    set_cfg(11, 2, 3, 4, 9, 1, 2, 3, 0, 5);
    run(250);
    // R7 / R8: enable update mid-frame, reload at the next boundary
    phase = "R7";
    cfg_update = 1'b1;
    run(160 + 480);
    // R1 with a non-zero polarity, then one frame of A inverted on vsync
    cfg_update = 1'b0;
    set_cfg(9, 1, 2, 3, 7, 0, 1, 2, 6, 2);
    rst = 1'b1;
    run(2);
    rst = 1'b0;
    run(200);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule